// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block performs one PCI configuration read or write on behalf of a host. Configuration space has no translation window of its own, so the block borrows one. It first widens window 0 until it covers window 1's local range, which hides window 1. It then points window 1 at configuration space and builds the configuration address. It performs the access and, after a write, reads the same location back. Finally it restores both windows to their normal memory duty.

The host presents bus number, device/function byte, register offset, access size, a read/write flag and write data with a single-cycle `req_valid`. It waits for the `done` pulse, which comes with `err` and, on success, the zero-extended read data. The translator is reprogrammed through a one-write-per-cycle register port (`wr_en`, `wr_sel`, `wr_data`). The data access uses a request/acknowledge bus on which `bus_req` is held until `bus_ack`.

Top module: `cfg_access_seq`

## Requirements
- R1: A request whose bus, devfn or offset input is 256 or more is rejected. `done` and `err` pulse in the cycle after acceptance, and no register write or bus access takes place.
- R2: For bus 0 with slot = devfn[7:3] of 12 or less, the configuration address has the function number devfn[2:0] in bits 10:8 and a single device-select bit at position slot+11. The window-1 map value is 0x0000000A, with type field [3:1] = 101 and bit 0 clear.
- R3: For bus 0 with slot above 12, the address carries only the function bits, and bit slot-5 is set in the window-1 map value in addition to 0x0000000A.
- R4: For a nonzero bus, the configuration address is bus<<16 | devfn<<8 and the map value is 0x0000000B (bit 0, low-address enable, set).
- R5: Opening writes, in consecutive cycles: select 0 (window-0 base) = 0x40000061 (512 MB), select 1 (window-1 base) = 0x61000011 (16 MB), select 2 (window-1 map) = the map value. A base word is local[31:20], then size code [7:4] (1=16 MB, 5=256 MB, 6=512 MB), then enable bit 0.
- R6: Closing writes, in consecutive cycles after the access: select 1 = 0x50000051, select 2 = 0x10000006 (type 011, PCI address 0x1000_0000), select 0 = 0x40000051. Select 3 (window-0 map) is never written.
- R7: A write access is followed by a read of the same address and size before closing. Both accesses fall between the third and fourth register write, and no register is written while `bus_req` is high.
- R8: The bus address equals 0x6100_0000 + configuration address + offset. `bus_size` is 1 or 2 for those sizes and 4 for any other size code.
- R9: A request is accepted only in idle. `busy` is high from the cycle after acceptance through the `done` cycle, and `done` falls 7 cycles plus the number of cycles `bus_req` is high after acceptance.
- R10: `rdata` holds the data of the last acknowledged access, right-aligned and zero-extended above the access size. After a write this is the read-back value.
- R11: `bus_req`, `bus_addr` and `bus_we` stay constant until the cycle of `bus_ack`, and each acknowledged access is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request strobe, taken only when idle |
| req_bus | input | IDX_W | bus number |
| req_devfn | input | IDX_W | device (7:3) and function (2:0) |
| req_offset | input | IDX_W | configuration register offset |
| req_size | input | 3 | access size in bytes (1, 2, else 4) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | write data |
| busy | output | 1 | operation in progress |
| done | output | 1 | single-cycle completion pulse |
| err | output | 1 | illegal request, valid with done |
| rdata | output | DATA_W | zero-extended read data |
| wr_en | output | 1 | translator register write strobe |
| wr_sel | output | 2 | 0 base0, 1 base1, 2 map1, 3 map0 |
| wr_data | output | 32 | translator register value |
| bus_req | output | 1 | data access request |
| bus_we | output | 1 | data access is a write |
| bus_addr | output | 32 | local access address |
| bus_size | output | 3 | access size in bytes |
| bus_wdata | output | DATA_W | access write data |
| bus_ack | input | 1 | access acknowledge |
| bus_rdata | input | DATA_W | right-aligned read data |

## Verification
`busy` is due one cycle after the accepting edge, and a rejected request gives `done` in that same cycle. For a legal request, `done` falls exactly 7 cycles plus the cycles spent with `bus_req` high. The bench counts those cycles itself against a responder with random latency of 0 to 2 cycles. Register writes and bus accesses are logged at the falling edge of the cycle in which they are presented. Each log is compared once the `done` pulse is seen, so the order and the position of the accesses among the writes are checked regardless of latency. `rdata` is sampled at the `done` cycle, two or more edges after the last acknowledge has been registered.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPEN_B0,
      ST_OPEN_B1,
      ST_OPEN_M1,
      ST_ACCESS,
      ST_READBACK,
      ST_CLOSE_B1,
      ST_CLOSE_M1,
      ST_CLOSE_B0,
      ST_FINISH
   } seq_state_e;

   typedef enum logic [1:0] {
      WSEL_BASE0 = 2'd0,
      WSEL_BASE1 = 2'd1,
      WSEL_MAP1  = 2'd2,
      WSEL_MAP0  = 2'd3
   } win_sel_e;

   localparam logic [3:0] SZC_16M  = 4'd1;
   localparam logic [3:0] SZC_256M = 4'd5;
   localparam logic [3:0] SZC_512M = 4'd6;

   localparam logic [2:0] MAPT_CONFIG    = 3'b101;
   localparam logic [2:0] MAPT_MEM_MULTI = 3'b011;

   function automatic logic [31:0] base_word(input logic [31:0] local_addr,
                                             input logic [3:0]  szc);
      return {local_addr[31:20], 12'd0, szc, 3'd0, 1'b1};
   endfunction

   function automatic logic [31:0] mem_map_word(input logic [31:0] pci_addr,
                                                input logic [2:0]  mtype);
      return {pci_addr[31:20], 16'd0, mtype, 1'b0};
   endfunction

endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
   import cfg_seq_pkg::*;
#(
   parameter logic [31:0] CFG_LOCAL  = 32'h6100_0000,
   parameter int          SPLIT_SLOT = 12
)(
   input  logic [7:0]  bus_num,
   input  logic [7:0]  devfn,
   input  logic [7:0]  reg_off,
   output logic [31:0] acc_addr,
   output logic [31:0] map_word
);

   initial begin
      assert (SPLIT_SLOT >= 8 && SPLIT_SLOT <= 12)
         else $error("SPLIT_SLOT must lie in 8..12");
      assert (CFG_LOCAL[23:0] == 24'd0)
         else $error("CFG_LOCAL must be 16 MB aligned");
   end

   logic [4:0]  slot;
   logic [2:0]  func;
   logic [23:0] cfg_off;

   assign slot = devfn[7:3];
   assign func = devfn[2:0];

   always_comb begin
      cfg_off  = '0;
      map_word = {28'd0, MAPT_CONFIG, 1'b0};
      if (bus_num == 8'd0) begin
         cfg_off[10:8] = func;
         if (int'(slot) > SPLIT_SLOT)
            map_word = map_word | (32'd1 << (slot - 5'd5));
         else
            cfg_off = cfg_off | (24'd1 << ({1'b0, slot} + 6'd11));
      end else begin
         cfg_off     = {bus_num, devfn, 8'h00};
         map_word[0] = 1'b1;
      end
   end

   assign acc_addr = CFG_LOCAL + {8'd0, cfg_off} + {24'd0, reg_off};

endmodule

// File: rtl/cfg_win_writer.sv
module cfg_win_writer
   import cfg_seq_pkg::*;
#(
   parameter logic [31:0] MEM_LOCAL  = 32'h4000_0000,
   parameter logic [31:0] CFG_LOCAL  = 32'h6100_0000,
   parameter logic [31:0] PREMEM_PCI = 32'h1000_0000
)(
   input  seq_state_e  state,
   input  logic [31:0] map_open,
   output logic        wr_en,
   output logic [1:0]  wr_sel,
   output logic [31:0] wr_data
);

   localparam logic [31:0] PREMEM_LOCAL = MEM_LOCAL + 32'h1000_0000;

   initial begin
      assert (MEM_LOCAL[28:0] == 29'd0)
         else $error("MEM_LOCAL must be 512 MB aligned");
      assert (PREMEM_PCI[19:0] == 20'd0)
         else $error("PREMEM_PCI must be 1 MB aligned");
      assert (CFG_LOCAL[23:0] == 24'd0)
         else $error("CFG_LOCAL must be 16 MB aligned");
   end

   always_comb begin
      wr_en   = 1'b1;
      wr_sel  = WSEL_BASE0;
      wr_data = '0;
      unique case (state)
         ST_OPEN_B0: begin
            wr_sel  = WSEL_BASE0;
            wr_data = base_word(MEM_LOCAL, SZC_512M);
         end
         ST_OPEN_B1: begin
            wr_sel  = WSEL_BASE1;
            wr_data = base_word(CFG_LOCAL, SZC_16M);
         end
         ST_OPEN_M1: begin
            wr_sel  = WSEL_MAP1;
            wr_data = map_open;
         end
         ST_CLOSE_B1: begin
            wr_sel  = WSEL_BASE1;
            wr_data = base_word(PREMEM_LOCAL, SZC_256M);
         end
         ST_CLOSE_M1: begin
            wr_sel  = WSEL_MAP1;
            wr_data = mem_map_word(PREMEM_PCI, MAPT_MEM_MULTI);
         end
         ST_CLOSE_B0: begin
            wr_sel  = WSEL_BASE0;
            wr_data = base_word(MEM_LOCAL, SZC_256M);
         end
         default: wr_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/cfg_rdata_fmt.sv
module cfg_rdata_fmt #(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] raw,
   input  logic [2:0]        nbytes,
   output logic [DATA_W-1:0] value
);

   localparam int LANES = DATA_W / 8;

   initial begin
      assert (DATA_W >= 32 && DATA_W % 8 == 0)
         else $error("DATA_W must be a byte multiple of at least 32");
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign value[ln*8 +: 8] = (ln < int'(nbytes)) ? raw[ln*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
   import cfg_seq_pkg::*;
#(
   parameter int          IDX_W      = 9,
   parameter int          DATA_W     = 32,
   parameter int          SPLIT_SLOT = 12,
   parameter bit          PIPE_ADDR  = 1'b1,
   parameter logic [31:0] MEM_LOCAL  = 32'h4000_0000,
   parameter logic [31:0] CFG_LOCAL  = 32'h6100_0000,
   parameter logic [31:0] PREMEM_PCI = 32'h1000_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_bus,
   input  logic [IDX_W-1:0]  req_devfn,
   input  logic [IDX_W-1:0]  req_offset,
   input  logic [2:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata,
   output logic              wr_en,
   output logic [1:0]        wr_sel,
   output logic [31:0]       wr_data,
   output logic              bus_req,
   output logic              bus_we,
   output logic [31:0]       bus_addr,
   output logic [2:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata
);

   initial begin
      assert (IDX_W >= 8) else $error("IDX_W must be at least 8");
   end

   seq_state_e        state;
   logic [7:0]        bus_q, devfn_q, off_q;
   logic [2:0]        nbytes_q;
   logic              write_q, err_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              over_range;
   logic [2:0]        nbytes_in;
   logic [31:0]       addr_c, map_c, addr_use, map_use;
   logic [DATA_W-1:0] fmt_data;

   // range check on the widened index inputs
   if (IDX_W > 8) begin : g_range
      assign over_range = (|req_bus[IDX_W-1:8]) | (|req_devfn[IDX_W-1:8]) |
                          (|req_offset[IDX_W-1:8]);
   end else begin : g_norange
      assign over_range = 1'b0;
   end

   assign nbytes_in = (req_size == 3'd1) ? 3'd1 :
                      (req_size == 3'd2) ? 3'd2 : 3'd4;

   cfg_addr_gen #(.CFG_LOCAL(CFG_LOCAL), .SPLIT_SLOT(SPLIT_SLOT)) u_addr (
      .bus_num (bus_q),
      .devfn   (devfn_q),
      .reg_off (off_q),
      .acc_addr(addr_c),
      .map_word(map_c)
   );

   if (PIPE_ADDR) begin : g_pipe
      logic [31:0] addr_r, map_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_r <= '0;
            map_r  <= '0;
         end else begin
            addr_r <= addr_c;
            map_r  <= map_c;
         end
      end
      assign addr_use = addr_r;
      assign map_use  = map_r;
   end else begin : g_comb
      assign addr_use = addr_c;
      assign map_use  = map_c;
   end

   cfg_win_writer #(
      .MEM_LOCAL (MEM_LOCAL),
      .CFG_LOCAL (CFG_LOCAL),
      .PREMEM_PCI(PREMEM_PCI)
   ) u_win (
      .state   (state),
      .map_open(map_use),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data)
   );

   cfg_rdata_fmt #(.DATA_W(DATA_W)) u_fmt (
      .raw   (bus_rdata),
      .nbytes(nbytes_q),
      .value (fmt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bus_q    <= '0;
         devfn_q  <= '0;
         off_q    <= '0;
         nbytes_q <= 3'd4;
         write_q  <= 1'b0;
         err_q    <= 1'b0;
         wdata_q  <= '0;
         rdata_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               bus_q    <= req_bus[7:0];
               devfn_q  <= req_devfn[7:0];
               off_q    <= req_offset[7:0];
               nbytes_q <= nbytes_in;
               write_q  <= req_write;
               wdata_q  <= req_wdata;
               err_q    <= over_range;
               rdata_q  <= '0;
               state    <= over_range ? ST_FINISH : ST_OPEN_B0;
            end
            ST_OPEN_B0:  state <= ST_OPEN_B1;
            ST_OPEN_B1:  state <= ST_OPEN_M1;
            ST_OPEN_M1:  state <= ST_ACCESS;
            ST_ACCESS: if (bus_ack) begin
               rdata_q <= fmt_data;
               state   <= write_q ? ST_READBACK : ST_CLOSE_B1;
            end
            ST_READBACK: if (bus_ack) begin
               rdata_q <= fmt_data;
               state   <= ST_CLOSE_B1;
            end
            ST_CLOSE_B1: state <= ST_CLOSE_M1;
            ST_CLOSE_M1: state <= ST_CLOSE_B0;
            ST_CLOSE_B0: state <= ST_FINISH;
            default:     state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FINISH);
   assign err       = done & err_q;
   assign rdata     = rdata_q;
   assign bus_req   = (state == ST_ACCESS) || (state == ST_READBACK);
   assign bus_we    = (state == ST_ACCESS) & write_q;
   assign bus_addr  = addr_use;
   assign bus_size  = nbytes_q;
   assign bus_wdata = wdata_q;

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);                                                     // R1
   AST_REJECT_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_q) |-> $past(state == ST_IDLE));                      // R1
   AST_TYPE0_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == WSEL_MAP1 && wr_data[3:1] == MAPT_CONFIG && bus_q == 8'd0)
      |-> !wr_data[0]);                                                  // R2
   AST_OPEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == WSEL_BASE1 && wr_data[7:4] == SZC_16M)
      |-> $past(wr_en && wr_sel == WSEL_BASE0 && wr_data[7:4] == SZC_512M)); // R5
   AST_MAP0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_sel != WSEL_MAP0);                                    // R6
   AST_NO_WRITE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !wr_en);                                               // R7
   AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));                                 // R9
   AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);                                                    // R9
   AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && bus_size == 3'd1) |-> rdata[DATA_W-1:8] == '0);   // R10
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R11

endmodule

// File: tb/cfg_access_seq_test.sv
module cfg_access_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int IDX_W      = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [IDX_W-1:0]  req_bus = '0, req_devfn = '0, req_offset = '0;
   logic [2:0]        req_size = 3'd4;
   logic              req_write = 1'b0;
   logic [31:0]       req_wdata = '0;
   logic              busy, done, err;
   logic [31:0]       rdata;
   logic              wr_en;
   logic [1:0]        wr_sel;
   logic [31:0]       wr_data;
   logic              bus_req, bus_we;
   logic [31:0]       bus_addr;
   logic [2:0]        bus_size;
   logic [31:0]       bus_wdata;
   logic              bus_ack = 1'b0;
   logic [31:0]       bus_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_access_seq #(.IDX_W(IDX_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
      .req_devfn(req_devfn), .req_offset(req_offset), .req_size(req_size),
      .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .done(done),
      .err(err), .rdata(rdata), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int vectors = 0;
   int miscompares = 0;

   // activity logs, filled by the responder/monitor
   logic [1:0]  wl_sel  [0:1023];
   logic [31:0] wl_data [0:1023];
   logic [31:0] tl_addr [0:255];
   logic        tl_we   [0:255];
   logic [2:0]  tl_size [0:255];
   logic [31:0] tl_wdat [0:255];
   logic [31:0] tl_rdat [0:255];
   int          tl_widx [0:255];
   int wr_n = 0, tx_n = 0, req_cyc = 0, lat = 0;

   always @(negedge clk) begin
      if (wr_en && wr_n < 1024) begin
         wl_sel[wr_n]  = wr_sel;
         wl_data[wr_n] = wr_data;
         wr_n++;
      end
      if (bus_req) req_cyc++;
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
         if (lat == 0) begin
            bus_ack   = 1'b1;
            bus_rdata = $urandom;
            if (tx_n < 256) begin
               tl_addr[tx_n] = bus_addr;
               tl_we[tx_n]   = bus_we;
               tl_size[tx_n] = bus_size;
               tl_wdat[tx_n] = bus_wdata;
               tl_rdat[tx_n] = bus_rdata;
               tl_widx[tx_n] = wr_n;
            end
            tx_n++;
            lat = $urandom % 3;
         end else lat--;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_map1(input logic [7:0] b, input logic [7:0] d);
      logic [31:0] m;
      m = 32'h0000_000A;
      if (b == 8'd0) begin
         if (d[7:3] > 5'd12) m = m | (32'd1 << (d[7:3] - 5'd5));
      end else m = m | 32'd1;
      return m;
   endfunction

   function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [7:0] d,
                                            input logic [7:0] o);
      logic [31:0] a;
      if (b == 8'd0) begin
         a = {21'd0, d[2:0], 8'd0};
         if (d[7:3] <= 5'd12) a = a | (32'd1 << (d[7:3] + 5'd11));
      end else a = {8'd0, b, d, 8'd0};
      return 32'h6100_0000 + a + {24'd0, o};
   endfunction

   task automatic run_op(input logic [IDX_W-1:0] b, input logic [IDX_W-1:0] d,
                         input logic [IDX_W-1:0] o, input logic [2:0] sz,
                         input logic we, input logic [31:0] wd, input bit poke);
      int wr0, tx0, rc0, cyc, nb, wr_after;
      bit legal;
      logic [31:0] mask, ea, em;
      string mtag;
      legal = (b < 256) && (d < 256) && (o < 256);
      nb = (sz == 3'd1) ? 1 : (sz == 3'd2) ? 2 : 4;
      mask = (nb == 1) ? 32'h0000_00FF : (nb == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      @(negedge clk);
      wr0 = wr_n; tx0 = tx_n; rc0 = req_cyc;
      req_valid = 1'b1; req_bus = b; req_devfn = d; req_offset = o;
      req_size = sz; req_write = we; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      chk("R9 busy after accept", {31'd0, busy}, 32'd1);
      if (poke && legal) begin
         req_valid = 1'b1; req_bus = 9'd7; req_devfn = 9'd9; req_offset = 9'd4;
         req_write = ~we;
      end
      while (!done && cyc < 200) begin
         @(negedge clk);
         req_valid = 1'b0;
         cyc++;
      end
      if (!legal) begin
         chk("R1 err", {31'd0, err}, 32'd1);
         chk("R1 reject latency", cyc, 1);
         chk("R1 no window writes", wr_n - wr0, 0);
         chk("R1 no bus access", tx_n - tx0, 0);
      end else begin
         ea = exp_addr(b[7:0], d[7:0], o[7:0]);
         em = exp_map1(b[7:0], d[7:0]);
         mtag = (b[7:0] != 8'd0) ? "R4 map" : (d[7:3] > 5'd12) ? "R3 map" : "R2 map";
         chk("R1 err clear", {31'd0, err}, 32'd0);
         chk("R9 done latency", cyc, (req_cyc - rc0) + 7);
         chk("R5 write count", wr_n - wr0, 6);
         if (wr_n - wr0 == 6) begin
            chk("R5 sel0", {30'd0, wl_sel[wr0]}, 32'd0);
            chk("R5 base0 wide", wl_data[wr0], 32'h4000_0061);
            chk("R5 sel1", {30'd0, wl_sel[wr0+1]}, 32'd1);
            chk("R5 base1 cfg", wl_data[wr0+1], 32'h6100_0011);
            chk("R5 sel2", {30'd0, wl_sel[wr0+2]}, 32'd2);
            chk(mtag, wl_data[wr0+2], em);
            chk("R6 sel1", {30'd0, wl_sel[wr0+3]}, 32'd1);
            chk("R6 base1 mem", wl_data[wr0+3], 32'h5000_0051);
            chk("R6 sel2", {30'd0, wl_sel[wr0+4]}, 32'd2);
            chk("R6 map1 mem", wl_data[wr0+4], 32'h1000_0006);
            chk("R6 sel0", {30'd0, wl_sel[wr0+5]}, 32'd0);
            chk("R6 base0 normal", wl_data[wr0+5], 32'h4000_0051);
         end
         chk("R11 access count", tx_n - tx0, we ? 2 : 1);
         if (tx_n - tx0 == (we ? 2 : 1)) begin
            chk("R8 address", tl_addr[tx0], ea);
            chk("R8 size", {29'd0, tl_size[tx0]}, nb);
            chk("R7 access between open and close", tl_widx[tx0], wr0 + 3);
            chk("R7 first access direction", {31'd0, tl_we[tx0]}, {31'd0, we});
            if (we) begin
               chk("R7 write data", tl_wdat[tx0], wd);
               chk("R7 readback is read", {31'd0, tl_we[tx0+1]}, 32'd0);
               chk("R7 readback address", tl_addr[tx0+1], ea);
               chk("R7 readback size", {29'd0, tl_size[tx0+1]}, nb);
               chk("R7 readback before close", tl_widx[tx0+1], wr0 + 3);
            end
            chk("R10 rdata", rdata, tl_rdat[tx_n-1] & mask);
         end
      end
      wr_after = wr_n;
      @(negedge clk);
      @(negedge clk);
      chk("R9 idle after done", {31'd0, busy}, 32'd0);
      chk("R9 request during busy ignored", wr_n, wr_after);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : main
      logic [IDX_W-1:0] rb, rd, ro;
      logic [2:0] rs;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk("R9 reset busy", {31'd0, busy}, 32'd0);
      chk("R9 reset done", {31'd0, done}, 32'd0);
      chk("R6 reset no write", {31'd0, wr_en}, 32'd0);
      chk("R11 reset no request", {31'd0, bus_req}, 32'd0);
      rst_n = 1'b1;
      // directed corners
      run_op(9'd0, {4'd0, 5'd0} , 9'd0,   3'd4, 1'b0, 32'h0, 1'b0);   // R2 slot 0
      run_op(9'd0, {1'b0, 5'd12, 3'd5}, 9'd8, 3'd1, 1'b0, 32'h0, 1'b0); // R2 slot 12
      run_op(9'd0, {1'b0, 5'd13, 3'd2}, 9'd4, 3'd2, 1'b0, 32'h0, 1'b0); // R3 slot 13
      run_op(9'd0, {1'b0, 5'd31, 3'd7}, 9'd252, 3'd4, 1'b1, 32'hCAFE_F00D, 1'b0); // R3 slot 31
      run_op(9'd5, 9'd33, 9'd16, 3'd2, 1'b1, 32'h1234_5678, 1'b0);  // R4 write, R7
      run_op(9'd255, 9'd255, 9'd255, 3'd3, 1'b0, 32'h0, 1'b0);      // R8 size code 3 -> 4
      run_op(9'd1, 9'd8, 9'd0, 3'd1, 1'b0, 32'h0, 1'b1);            // R9 poke while busy
      run_op(9'd256, 9'd0, 9'd0, 3'd4, 1'b0, 32'h0, 1'b0);          // R1 bus
      run_op(9'd0, 9'd300, 9'd0, 3'd4, 1'b1, 32'h0, 1'b0);          // R1 devfn
      run_op(9'd3, 9'd0, 9'd256, 3'd2, 1'b0, 32'h0, 1'b0);          // R1 offset
      // constrained random
      for (int n = 0; n < 60; n++) begin
         rb = ($urandom % 3 == 0) ? 9'd0 : 9'($urandom % 256);
         rd = 9'($urandom % 256);
         ro = 9'($urandom % 256);
         if ($urandom % 10 == 0) rb[8] = 1'b1;
         if ($urandom % 12 == 0) ro[8] = 1'b1;
         case ($urandom % 3)
            0: rs = 3'd1;
            1: rs = 3'd2;
            default: rs = 3'd4;
         endcase
         run_op(rb, rd, ro, rs, 1'($urandom % 2), $urandom, 1'($urandom % 4 == 0));
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule